// File: doc/BRIEF.md
# Flash Module Configuration Controller

This block keeps the configuration and control state that sits beside an embedded flash array. At a synchronous reset it takes its starting values from a set of shadow inputs and from a strap pin. It then exposes that state through a small register port. The state covers a halt bit, a freeze-permission bit, a boot-disable bit, a write-once lock and a two-bit array-space field. A separate control register holds the program-enable bit, and a small bank holds the bootstrap vectors.

Three results come out of that state. The first is a registered high-voltage enable for program/erase, gated by halt, freeze and freeze permission. The second is a bootstrap window that answers the first program-space reads of the low even addresses with the vector words, and shuts for good once the last vector has been read. The third is an array-access accept signal, decoded from the bus address, the supervisor/program qualifiers and the array-space field.

Top module: `flash_cfg_ctrl`

## Requirements
- R1: On a clock edge with `rst` high, the registers load as follows. Halt becomes 1 if `strap_n` is 0 or `shd_stop` is 1. Boot-disable, lock and space take `shd_boot`, `shd_lock` and `shd_space`. Freeze permission, program-enable, all vectors and `hv_en` become 0.
- R2: The register map is fixed. Index 0 is configuration: bit0 halt, bit1 freeze permission, bit2 boot-disable, bit3 lock, bits5:4 space, all other bits read 0. Index 1 is control, with bit0 program-enable. Indices 2 to 5 are bootstrap vectors 0 to 3. Other indices read 0. `reg_rdata` shows the current contents without delay.
- R3: The halt bit takes `reg_wdata[0]` on every write to index 0, whatever the lock state.
- R4: The lock bit can go from 0 to 1 by a write with bit3 set. Writes never clear it; only reset does.
- R5: While lock is 1, writes to freeze permission, boot-disable, space and the vectors are dropped, and their read-back stays unchanged. Program-enable stays writable.
- R6: The space field is written only when lock is 0 and halt is 1, both as they stood before the write.
- R7: `hv_en` is the value of program-enable AND NOT halt AND (freeze permission OR NOT `freeze`), registered once. Halt does not change the program-enable bit.
- R8: The bootstrap window is open after reset when the reset-time boot-disable and halt are both 0. While it is open and halt and boot-disable are currently 0, a valid program-space read at an even address from 0 to 6 sets `bus_hit` and returns vector `addr[2:1]` on `bus_rdata`. Odd addresses, data-space reads and writes do not hit.
- R9: A hit at address 6 closes the window on that clock edge. After that no address hits until the next reset.
- R10: `arr_accept` is 1 only for a valid access when all of these hold: the address is in [ARRAY_BASE, ARRAY_BASE+ARRAY_BYTES), halt is 0, space bit1 is 1, `bus_super` is 1, and `bus_prog` is 1 if space bit0 is 1 (10 = supervisor program and data, 11 = supervisor program only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_n | input | 1 | Strap pin sampled at reset; 0 forces halt |
| shd_stop | input | 1 | Shadow value for halt |
| shd_boot | input | 1 | Shadow value for boot-disable |
| shd_lock | input | 1 | Shadow value for lock |
| shd_space | input | 2 | Shadow value for space field |
| freeze | input | 1 | Debug freeze indication |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Register index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| bus_valid | input | 1 | Bus access valid |
| bus_rd | input | 1 | Bus access is a read |
| bus_prog | input | 1 | Program-space qualifier |
| bus_super | input | 1 | Supervisor qualifier |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_hit | output | 1 | Bootstrap vector response |
| bus_rdata | output | DATA_W | Bootstrap vector data |
| arr_accept | output | 1 | Array access accepted |
| hv_en | output | 1 | Program/erase voltage enable |

## Verification
The reset load is swept over every combination of the strap pin and the shadow inputs. This tells the pin-driven halt apart from the shadow-driven halt. The voltage gate is swept over all sixteen settings of program-enable, halt, freeze permission and freeze, so each gating term is seen to act alone. The access decode runs through every space code with every qualifier pair, with halt both set and clear, and also at both edges of the array range. Fixed write sequences then separate the write rules: the halt-then-space ordering, the single lock setting, dropped vector writes, and the bootstrap window closing only after the read of the last vector.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
   typedef struct packed {
      logic [1:0] space;
      logic       lock;
      logic       boot;
      logic       frz_ok;
      logic       halt;
   } cfg_t;

   localparam int CFG_BITS = 6;
   localparam int IDX_CFG  = 0;
   localparam int IDX_CTL  = 1;
   localparam int IDX_VEC0 = 2;
endpackage

// File: rtl/fcc_cfg_regs.sv
module fcc_cfg_regs
   import fcc_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int SEL_W   = 3,
   parameter int NUM_VEC = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           halt_rst,
   input  logic                           shd_boot,
   input  logic                           shd_lock,
   input  logic [1:0]                     shd_space,
   input  logic                           reg_wr,
   input  logic [SEL_W-1:0]               reg_sel,
   input  logic [DATA_W-1:0]              reg_wdata,
   output logic [DATA_W-1:0]              reg_rdata,
   output cfg_t                           cfg,
   output logic                           pgm_en,
   output logic [NUM_VEC-1:0][DATA_W-1:0] vec
);
   localparam int NUM_REGS = IDX_VEC0 + NUM_VEC;

   if (DATA_W < CFG_BITS) begin : g_bad_width
      $error("DATA_W too small for configuration fields");
   end
   if ((1 << SEL_W) < NUM_REGS) begin : g_bad_sel
      $error("SEL_W cannot reach every register");
   end

   cfg_t cfg_q;
   logic pgm_q;
   logic wr_cfg, wr_ctl;

   assign wr_cfg = reg_wr && (reg_sel == SEL_W'(IDX_CFG));
   assign wr_ctl = reg_wr && (reg_sel == SEL_W'(IDX_CTL));

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q.halt   <= halt_rst;
         cfg_q.frz_ok <= 1'b0;
         cfg_q.boot   <= shd_boot;
         cfg_q.lock   <= shd_lock;
         cfg_q.space  <= shd_space;
      end else if (wr_cfg) begin
         cfg_q.halt <= reg_wdata[0];
         cfg_q.lock <= cfg_q.lock | reg_wdata[3];
         if (!cfg_q.lock) begin
            cfg_q.frz_ok <= reg_wdata[1];
            cfg_q.boot   <= reg_wdata[2];
            if (cfg_q.halt) cfg_q.space <= reg_wdata[5:4];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         pgm_q <= 1'b0;
      else if (wr_ctl) pgm_q <= reg_wdata[0];
   end

   for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
      logic wr_v;
      assign wr_v = reg_wr && (reg_sel == SEL_W'(IDX_VEC0 + i)) && !cfg_q.lock;
      always_ff @(posedge clk) begin
         if (rst)       vec[i] <= '0;
         else if (wr_v) vec[i] <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel == SEL_W'(IDX_CFG))      reg_rdata[CFG_BITS-1:0] = cfg_q;
      else if (reg_sel == SEL_W'(IDX_CTL)) reg_rdata[0] = pgm_q;
      else begin
         for (int i = 0; i < NUM_VEC; i++)
            if (reg_sel == SEL_W'(IDX_VEC0 + i)) reg_rdata = vec[i];
      end
   end

   assign cfg    = cfg_q;
   assign pgm_en = pgm_q;

   assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      cfg_q.lock |=> cfg_q.lock);
   assert_space_guard_R6: assert property (@(posedge clk) disable iff (rst)
      (cfg_q.lock || !cfg_q.halt) |=> $stable(cfg_q.space));
endmodule

// File: rtl/fcc_hv_gate.sv
module fcc_hv_gate (
   input  logic clk,
   input  logic rst,
   input  logic pgm_en,
   input  logic halt,
   input  logic frz_ok,
   input  logic freeze,
   output logic hv_en
);
   logic hv_q;

   always_ff @(posedge clk) begin
      if (rst) hv_q <= 1'b0;
      else     hv_q <= pgm_en && !halt && (frz_ok || !freeze);
   end

   assign hv_en = hv_q;

   assert_hv_off_halted_R7: assert property (@(posedge clk) disable iff (rst)
      hv_q |-> $past(!halt && pgm_en));
endmodule

// File: rtl/fcc_boot_window.sv
module fcc_boot_window #(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 16,
   parameter int NUM_VEC = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           open_rst,
   input  logic                           halt,
   input  logic                           boot,
   input  logic                           bus_valid,
   input  logic                           bus_rd,
   input  logic                           bus_prog,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [NUM_VEC-1:0][DATA_W-1:0] vec,
   output logic                           hit,
   output logic [DATA_W-1:0]              rdata
);
   localparam int VEC_AW = $clog2(NUM_VEC);

   if (NUM_VEC < 2 || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_vec
      $error("NUM_VEC must be a power of two, at least 2");
   end
   if (ADDR_W <= VEC_AW + 1) begin : g_bad_addr
      $error("ADDR_W too small for the bootstrap window");
   end

   logic              open_q;
   logic [VEC_AW-1:0] idx;
   logic              in_win;

   assign idx    = bus_addr[VEC_AW:1];
   assign in_win = (bus_addr[ADDR_W-1:VEC_AW+1] == '0) && !bus_addr[0];
   assign hit    = open_q && !halt && !boot && bus_valid && bus_rd && bus_prog && in_win;
   assign rdata  = hit ? vec[idx] : '0;

   always_ff @(posedge clk) begin
      if (rst)                                       open_q <= open_rst;
      else if (hit && idx == VEC_AW'(NUM_VEC - 1))   open_q <= 1'b0;
   end

   assert_window_once_R9: assert property (@(posedge clk) disable iff (rst)
      !open_q |=> !open_q);
   assert_hit_needs_open_R8: assert property (@(posedge clk) disable iff (rst)
      hit |-> open_q);
endmodule

// File: rtl/fcc_space_decode.sv
module fcc_space_decode #(
   parameter int          ADDR_W      = 24,
   parameter logic [31:0] ARRAY_BASE  = 32'h0001_0000,
   parameter logic [31:0] ARRAY_BYTES = 32'h0001_8000
) (
   input  logic              bus_valid,
   input  logic              bus_prog,
   input  logic              bus_super,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              halt,
   input  logic [1:0]        space,
   input  logic              boot_hit,
   output logic              accept
);
   localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(ARRAY_BASE);
   localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(ARRAY_BASE + ARRAY_BYTES);

   if (ARRAY_BYTES == 0) begin : g_bad_size
      $error("ARRAY_BYTES must be nonzero");
   end

   logic in_range, space_ok;

   assign in_range = ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI);
   assign space_ok = space[1] && bus_super && (bus_prog || !space[0]);
   assign accept   = bus_valid && in_range && !halt && space_ok && !boot_hit;
endmodule

// File: rtl/flash_cfg_ctrl.sv
module flash_cfg_ctrl
   import fcc_pkg::*;
#(
   parameter int          ADDR_W      = 24,
   parameter int          DATA_W      = 16,
   parameter int          NUM_VEC     = 4,
   parameter int          SEL_W       = 3,
   parameter logic [31:0] ARRAY_BASE  = 32'h0001_0000,
   parameter logic [31:0] ARRAY_BYTES = 32'h0001_8000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strap_n,
   input  logic              shd_stop,
   input  logic              shd_boot,
   input  logic              shd_lock,
   input  logic [1:0]        shd_space,
   input  logic              freeze,
   input  logic              reg_wr,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bus_valid,
   input  logic              bus_rd,
   input  logic              bus_prog,
   input  logic              bus_super,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              bus_hit,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              arr_accept,
   output logic              hv_en
);
   cfg_t                           cfg;
   logic                           pgm_en;
   logic [NUM_VEC-1:0][DATA_W-1:0] vec;
   logic                           halt_rst;

   assign halt_rst = !strap_n || shd_stop;

   fcc_cfg_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_VEC(NUM_VEC)) u_regs (
      .clk(clk), .rst(rst), .halt_rst(halt_rst), .shd_boot(shd_boot),
      .shd_lock(shd_lock), .shd_space(shd_space), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cfg(cfg), .pgm_en(pgm_en), .vec(vec));

   fcc_hv_gate u_hv (
      .clk(clk), .rst(rst), .pgm_en(pgm_en), .halt(cfg.halt),
      .frz_ok(cfg.frz_ok), .freeze(freeze), .hv_en(hv_en));

   fcc_boot_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_boot (
      .clk(clk), .rst(rst), .open_rst(!shd_boot && !halt_rst),
      .halt(cfg.halt), .boot(cfg.boot), .bus_valid(bus_valid), .bus_rd(bus_rd),
      .bus_prog(bus_prog), .bus_addr(bus_addr), .vec(vec),
      .hit(bus_hit), .rdata(bus_rdata));

   fcc_space_decode #(.ADDR_W(ADDR_W), .ARRAY_BASE(ARRAY_BASE),
                      .ARRAY_BYTES(ARRAY_BYTES)) u_dec (
      .bus_valid(bus_valid), .bus_prog(bus_prog), .bus_super(bus_super),
      .bus_addr(bus_addr), .halt(cfg.halt), .space(cfg.space),
      .boot_hit(bus_hit), .accept(arr_accept));

   assert_accept_qual_R10: assert property (@(posedge clk) disable iff (rst)
      arr_accept |-> (bus_super && !bus_hit));
endmodule

// File: tb/flash_cfg_ctrl_tb.sv
module flash_cfg_ctrl_tb_top;
   localparam int ADDR_W = 24;
   localparam int DATA_W = 16;
   localparam logic [23:0] BASE = 24'h01_0000;
   localparam logic [23:0] TOPX = 24'h02_8000;

   logic clk = 0, rst = 0;
   logic strap_n = 1, shd_stop = 0, shd_boot = 1, shd_lock = 0;
   logic [1:0] shd_space = 2'b10;
   logic freeze = 0, reg_wr = 0;
   logic [2:0] reg_sel = 0;
   logic [DATA_W-1:0] reg_wdata = 0, reg_rdata, bus_rdata;
   logic bus_valid = 0, bus_rd = 0, bus_prog = 0, bus_super = 0;
   logic [ADDR_W-1:0] bus_addr = 0;
   logic bus_hit, arr_accept, hv_en;
   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   flash_cfg_ctrl dut_i (
      .clk(clk), .rst(rst), .strap_n(strap_n), .shd_stop(shd_stop),
      .shd_boot(shd_boot), .shd_lock(shd_lock), .shd_space(shd_space),
      .freeze(freeze), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
      .bus_rd(bus_rd), .bus_prog(bus_prog), .bus_super(bus_super),
      .bus_addr(bus_addr), .bus_hit(bus_hit), .bus_rdata(bus_rdata),
      .arr_accept(arr_accept), .hv_en(hv_en));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic pn, input logic ss, input logic sb,
                           input logic sl, input logic [1:0] sp);
      @(negedge clk);
      strap_n = pn; shd_stop = ss; shd_boot = sb; shd_lock = sl; shd_space = sp;
      rst = 1;
      @(negedge clk);
      rst = 0;
   endtask

   task automatic wr(input logic [2:0] sel, input logic [15:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   function automatic logic [15:0] rd(input logic [2:0] sel);
      reg_sel = sel;
      return reg_rdata;
   endfunction

   task automatic peek(input logic [2:0] sel, output logic [15:0] v);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      logic [15:0] v;
      // R1 / R2: reset load over every strap and shadow combination
      for (int c = 0; c < 64; c++) begin
         logic pn, ss, sb, sl; logic [1:0] sp;
         {pn, ss, sb, sl, sp} = 6'(c);
         do_reset(pn, ss, sb, sl, sp);
         peek(0, v);
         chk("R1 cfg reset", v, {10'd0, sp, sl, sb, 1'b0, (!pn || ss)});
         peek(1, v);
         chk("R1 ctl reset", v, 0);
         chk("R1 hv reset", hv_en, 0);
      end
      // R2 unused index reads zero
      peek(7, v);
      chk("R2 unused index", v, 0);

      // R6 / R3 / R4 / R5 write-rule sequence
      do_reset(1, 1, 1, 0, 2'b00);
      wr(0, 16'h0021);                 // halt=1, space=10
      peek(0, v); chk("R6 space written while halted", v[5:4], 2'b10);
      wr(0, 16'h0030);                 // old halt=1 -> space=11, halt->0
      peek(0, v); chk("R6 space uses prior halt", v, 16'h0030);
      wr(0, 16'h0000);                 // halt=0 -> space kept
      peek(0, v); chk("R6 space blocked when running", v[5:4], 2'b11);
      wr(4, 16'hA5A5);
      wr(0, 16'h001F);                 // lock, boot, frz, halt; space blocked (halt was 0)
      peek(0, v); chk("R4 lock set once", v, 16'h003F);
      wr(0, 16'h0000);                 // try to clear all
      peek(0, v); chk("R3 halt clears under lock", v[0], 0);
      chk("R4 lock stays set", v[3], 1);
      chk("R5 frz/boot kept under lock", v[2:1], 2'b11);
      wr(0, 16'h0001);
      wr(0, 16'h0001);                 // halt=1 but locked, space write dropped
      peek(0, v); chk("R5 space kept under lock", v[5:4], 2'b11);
      wr(4, 16'h1234);
      peek(4, v); chk("R5 vector write dropped", v, 16'hA5A5);
      wr(1, 16'h0001);
      peek(1, v); chk("R5 control still writable", v, 16'h0001);

      // R7: voltage gating over all sixteen settings
      do_reset(1, 0, 1, 0, 2'b10);
      for (int c = 0; c < 16; c++) begin
         logic p, h, f, z;
         {p, h, f, z} = 4'(c);
         freeze = z;
         wr(0, {14'd0, f, h});
         wr(1, {15'd0, p});
         @(negedge clk);
         chk("R7 hv gate", hv_en, p && !h && (f || !z));
         peek(1, v); chk("R7 enable kept through halt", v[0], p);
      end
      freeze = 0;

      // R8 / R9: bootstrap window
      do_reset(1, 0, 0, 0, 2'b10);
      for (int i = 0; i < 4; i++) wr(3'(2 + i), 16'h1000 + 16'(i * 16'h111));
      bus_valid = 1; bus_rd = 1; bus_prog = 1; bus_super = 1;
      for (int i = 0; i < 3; i++) begin
         bus_addr = 24'(2 * i); #1;
         chk("R8 vector hit", bus_hit, 1);
         chk("R8 vector data", bus_rdata, 16'h1000 + 16'(i * 16'h111));
         chk("R8 hit blocks array accept", arr_accept, 0);
         @(negedge clk);
      end
      bus_addr = 24'h000001; #1; chk("R8 odd address no hit", bus_hit, 0);
      bus_addr = 24'h000000; bus_prog = 0; #1; chk("R8 data space no hit", bus_hit, 0);
      bus_prog = 1; bus_rd = 0; #1; chk("R8 write no hit", bus_hit, 0);
      bus_rd = 1; bus_addr = 24'h000008; #1; chk("R8 above window no hit", bus_hit, 0);
      bus_addr = 24'h000000; #1; chk("R9 still open before last read", bus_hit, 1);
      bus_addr = 24'h000006; #1;
      chk("R9 last vector hit", bus_hit, 1);
      chk("R9 last vector data", bus_rdata, 16'h1333);
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         bus_addr = 24'(2 * i); #1;
         chk("R9 window closed", bus_hit, 0);
      end
      do_reset(1, 0, 1, 0, 2'b10);
      bus_addr = 0; #1; chk("R8 boot-disable shadow closes window", bus_hit, 0);
      do_reset(0, 0, 0, 0, 2'b10);
      #1; chk("R8 strap halt closes window", bus_hit, 0);
      wr(0, 16'h0020);
      #1; chk("R8 window stays shut after halt clear", bus_hit, 0);

      // R10: access decode over space, qualifiers and halt
      for (int c = 0; c < 32; c++) begin
         logic [1:0] sp; logic su, pr, h;
         {sp, su, pr, h} = 5'(c);
         do_reset(1, h, 1, 0, sp);
         bus_valid = 1; bus_rd = 1; bus_super = su; bus_prog = pr;
         bus_addr = BASE + 24'h100; #1;
         chk("R10 decode", arr_accept, !h && sp[1] && su && (pr || !sp[0]));
         bus_addr = BASE; #1;
         chk("R10 low edge", arr_accept, !h && sp[1] && su && (pr || !sp[0]));
         bus_addr = BASE - 24'd2; #1; chk("R10 below range", arr_accept, 0);
         bus_addr = TOPX - 24'd2; #1;
         chk("R10 high edge", arr_accept, !h && sp[1] && su && (pr || !sp[0]));
         bus_addr = TOPX; #1; chk("R10 above range", arr_accept, 0);
         bus_valid = 0; bus_addr = BASE; #1; chk("R10 invalid no accept", arr_accept, 0);
      end
      bus_valid = 0;

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule